// File: doc/BRIEF.md
# Multidrop Address Recognition Controller

This block sits behind a serial receiver on a shared 9-bit "party line" bus. The ninth bit of each character, normally parity, instead tags the character. A one tags it as an address and a zero tags it as data. The controller compares each address character with a set of programmed station addresses. It then decides which characters reach the receive buffer and whether the receiver stays enabled.

There are four operating modes. In the host mode, software opens and closes the receiver with command pulses. While the receiver is open, every character goes to the buffer with its ninth bit attached. In the three automatic modes, address matches drive the receiver enable without software help:

- The full mode both opens and closes the receiver.
- The wake mode only opens it.
- The sleep mode only closes it.

A second address slot lets a station also answer to a group address. A configuration bit chooses whether a matching address character is itself passed on.

Top module: `mdrop_addr_ctrl`

## Requirements
- R1: A character with ninth bit 1 is an address and with ninth bit 0 is data. `match_o` is updated only by address characters: it goes to 1 when the address hits an enabled slot and to 0 otherwise, and it holds its value across data characters.
- R2: Outputs are registered. A character strobed in cycle t that is accepted shows `acc_o`=1 in cycle t+1, with `acc_chr_o` = {ninth bit, 8-bit character}.
- R3: In host mode (`mode_i`=2'b00), every character is accepted exactly when the receiver is enabled. `rx_en_o` changes only through `host_en_i` / `host_dis_i`, and `host_dis_i` wins when both are pulsed together.
- R4: In full automatic mode (`mode_i`=2'b01), an address that hits enables the receiver and any other address disables it. The host command inputs are ignored in this mode.
- R5: Address slot k (k=0,1) is compared only while `slot_on_i[k]`=1. Slot 1 serves as the group address, and `slot_addr_i[8k+7:8k]` holds slot k.
- R6: In every automatic mode, an address that hits is accepted exactly when `keep_addr_i`=1. An address that misses is never accepted.
- R7: In every mode, a data character that arrives while the receiver is disabled is discarded: no `acc_o` and no change to `match_o`.
- R8: In wake mode (`mode_i`=2'b10), an address that hits enables the receiver. An address that misses leaves it enabled. The host commands still act.
- R9: In sleep mode (`mode_i`=2'b11), an address that misses disables the receiver. An address that hits does not enable it; only `host_en_i` does.
- R10: After reset, `acc_o`, `match_o` and `rx_en_o` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| mode_i | input | 2 | 00 host, 01 full automatic, 10 wake, 11 sleep |
| keep_addr_i | input | 1 | Pass matching address characters to the buffer |
| slot_addr_i | input | 16 | Station addresses, slot k in bits [8k+7:8k] |
| slot_on_i | input | 2 | Per-slot compare enable |
| chr_vld_i | input | 1 | Received character strobe |
| chr_i | input | 8 | Received character |
| ninth_i | input | 1 | Ninth bit: 1 address, 0 data |
| host_en_i | input | 1 | Host command: enable receiver |
| host_dis_i | input | 1 | Host command: disable receiver |
| acc_o | output | 1 | Character accepted into the buffer |
| acc_chr_o | output | 9 | Accepted character with its ninth bit on top |
| match_o | output | 1 | Last address character hit a slot |
| rx_en_o | output | 1 | Receiver enabled |

## Verification
The bench uses the default build: 8-bit characters and two address slots, with slot 0 as the station address and slot 1 as the group address. Two slots let the bench reach group addressing. They also let it switch the group slot off, so that the same address byte first hits and then misses. All four modes run in turn against a scoreboard that holds the expected accepted characters. The bench also checks the enable and match outputs after every character.

// File: rtl/mdrop_pkg.sv
package mdrop_pkg;
   typedef enum logic [1:0] {
      MD_HOST  = 2'b00,
      MD_FULL  = 2'b01,
      MD_WAKE  = 2'b10,
      MD_SLEEP = 2'b11
   } md_mode_e;

   // automatic mode may raise the enable on a hit
   function automatic logic md_sets(md_mode_e m);
      return (m == MD_FULL) || (m == MD_WAKE);
   endfunction

   // automatic mode may drop the enable on a miss
   function automatic logic md_clears(md_mode_e m);
      return (m == MD_FULL) || (m == MD_SLEEP);
   endfunction

   // host commands are honoured
   function automatic logic md_host_ok(md_mode_e m);
      return m != MD_FULL;
   endfunction
endpackage

// File: rtl/mdrop_addr_cmp.sv
module mdrop_addr_cmp #(
   parameter int DW    = 8,
   parameter int NSLOT = 2
) (
   input  logic [DW-1:0]       chr_i,
   input  logic [NSLOT*DW-1:0] slot_addr_i,
   input  logic [NSLOT-1:0]    slot_on_i,
   output logic                hit_o
);
   logic [NSLOT-1:0] slot_hit;

   for (genvar k = 0; k < NSLOT; k++) begin : g_slot
      assign slot_hit[k] = slot_on_i[k] && (chr_i == slot_addr_i[k*DW +: DW]);
   end

   assign hit_o = |slot_hit;
endmodule

// File: rtl/mdrop_en_fsm.sv
module mdrop_en_fsm
   import mdrop_pkg::*;
(
   input  logic     clk,
   input  logic     rst_n,
   input  md_mode_e mode_i,
   input  logic     chr_vld_i,
   input  logic     is_addr_i,
   input  logic     hit_i,
   input  logic     host_en_i,
   input  logic     host_dis_i,
   output logic     rx_en_o
);
   logic rx_en_q, rx_en_d;
   logic addr_evt;

   assign addr_evt = chr_vld_i && is_addr_i && (mode_i != MD_HOST);

   always_comb begin
      rx_en_d = rx_en_q;
      if (md_host_ok(mode_i) && (host_en_i || host_dis_i)) begin
         rx_en_d = !host_dis_i;
      end else if (addr_evt) begin
         if (hit_i && md_sets(mode_i))        rx_en_d = 1'b1;
         else if (!hit_i && md_clears(mode_i)) rx_en_d = 1'b0;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) rx_en_q <= 1'b0;
      else        rx_en_q <= rx_en_d;
   end

   assign rx_en_o = rx_en_q;

   AST_HOST_NO_AUTO: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_i == MD_HOST && !host_en_i && !host_dis_i) |=> $stable(rx_en_q)); // R3
   AST_FULL_HIT_OPENS: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_i == MD_FULL && chr_vld_i && is_addr_i && hit_i) |=> rx_en_q); // R4
   AST_FULL_IGNORES_HOST: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_i == MD_FULL && !chr_vld_i) |=> $stable(rx_en_q)); // R4
   AST_WAKE_MISS_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_i == MD_WAKE && chr_vld_i && is_addr_i && !hit_i && rx_en_q
       && !host_dis_i) |=> rx_en_q); // R8
   AST_SLEEP_HIT_NO_OPEN: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_i == MD_SLEEP && !rx_en_q && !host_en_i) |=> !rx_en_q); // R9
endmodule

// File: rtl/mdrop_pass_sel.sv
module mdrop_pass_sel
   import mdrop_pkg::*;
#(
   parameter int DW = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  md_mode_e      mode_i,
   input  logic          keep_addr_i,
   input  logic          chr_vld_i,
   input  logic          is_addr_i,
   input  logic [DW-1:0] chr_i,
   input  logic          hit_i,
   input  logic          rx_en_i,
   output logic          acc_o,
   output logic [DW:0]   acc_chr_o,
   output logic          match_o
);
   logic          take;
   logic          acc_q, match_q;
   logic [DW:0]   chr_q;

   always_comb begin
      if (!chr_vld_i)                       take = 1'b0;
      else if (mode_i == MD_HOST)           take = rx_en_i;
      else if (is_addr_i)                   take = hit_i && keep_addr_i;
      else                                  take = rx_en_i;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         acc_q   <= 1'b0;
         match_q <= 1'b0;
         chr_q   <= '0;
      end else begin
         acc_q <= take;
         if (take) chr_q <= {is_addr_i, chr_i};
         if (chr_vld_i && is_addr_i) match_q <= hit_i;
      end
   end

   assign acc_o     = acc_q;
   assign acc_chr_o = chr_q;
   assign match_o   = match_q;

   AST_ACC_NEEDS_CHAR: assert property (@(posedge clk) disable iff (!rst_n)
      !chr_vld_i |=> !acc_q); // R2
   AST_NO_DATA_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
      (chr_vld_i && !is_addr_i && !rx_en_i) |=> !acc_q); // R7
   AST_MISS_DROPPED: assert property (@(posedge clk) disable iff (!rst_n)
      (chr_vld_i && is_addr_i && !hit_i && mode_i != MD_HOST) |=> !acc_q); // R6
   AST_MATCH_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      !(chr_vld_i && is_addr_i) |=> $stable(match_q)); // R1
endmodule

// File: rtl/mdrop_addr_ctrl.sv
module mdrop_addr_ctrl
   import mdrop_pkg::*;
#(
   parameter int DW    = 8,
   parameter int NSLOT = 2
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [1:0]          mode_i,
   input  logic                keep_addr_i,
   input  logic [NSLOT*DW-1:0] slot_addr_i,
   input  logic [NSLOT-1:0]    slot_on_i,
   input  logic                chr_vld_i,
   input  logic [DW-1:0]       chr_i,
   input  logic                ninth_i,
   input  logic                host_en_i,
   input  logic                host_dis_i,
   output logic                acc_o,
   output logic [DW:0]         acc_chr_o,
   output logic                match_o,
   output logic                rx_en_o
);
   if (DW < 1 || DW > 32) begin : g_bad_dw
      $error("mdrop_addr_ctrl: DW out of range");
   end
   if (NSLOT < 1 || NSLOT > 8) begin : g_bad_nslot
      $error("mdrop_addr_ctrl: NSLOT out of range");
   end

   md_mode_e mode;
   logic     hit;
   logic     rx_en;

   assign mode = md_mode_e'(mode_i);

   mdrop_addr_cmp #(.DW(DW), .NSLOT(NSLOT)) cmp_i (
      .chr_i       (chr_i),
      .slot_addr_i (slot_addr_i),
      .slot_on_i   (slot_on_i),
      .hit_o       (hit)
   );

   mdrop_en_fsm fsm_i (
      .clk        (clk),
      .rst_n      (rst_n),
      .mode_i     (mode),
      .chr_vld_i  (chr_vld_i),
      .is_addr_i  (ninth_i),
      .hit_i      (hit),
      .host_en_i  (host_en_i),
      .host_dis_i (host_dis_i),
      .rx_en_o    (rx_en)
   );

   mdrop_pass_sel #(.DW(DW)) sel_i (
      .clk         (clk),
      .rst_n       (rst_n),
      .mode_i      (mode),
      .keep_addr_i (keep_addr_i),
      .chr_vld_i   (chr_vld_i),
      .is_addr_i   (ninth_i),
      .chr_i       (chr_i),
      .hit_i       (hit),
      .rx_en_i     (rx_en),
      .acc_o       (acc_o),
      .acc_chr_o   (acc_chr_o),
      .match_o     (match_o)
   );

   assign rx_en_o = rx_en;

   AST_RESET_QUIET: assert property (@(posedge clk)
      !rst_n |=> (!acc_o && !rx_en_o && !match_o)); // R10
endmodule

// File: tb/mdrop_addr_ctrl_tb_top.sv
`timescale 1ns/1ps
module mdrop_addr_ctrl_tb_top;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [1:0]  mode = 2'b00;
   logic        keep = 1'b0;
   logic [15:0] slots = 16'h3C5A;
   logic [1:0]  slot_on = 2'b11;
   logic        vld = 1'b0;
   logic [7:0]  chr = '0;
   logic        ninth = 1'b0;
   logic        hen = 1'b0, hdis = 1'b0;
   logic        acc, match, rx_en;
   logic [8:0]  acc_chr;

   int total = 0, bad = 0;
   logic m_en = 1'b0, m_match = 1'b0;
   logic [8:0] expq[$];
   string      reqq[$];

   always #4 clk = ~clk;

   mdrop_addr_ctrl dut_i (
      .clk(clk), .rst_n(rst_n), .mode_i(mode), .keep_addr_i(keep),
      .slot_addr_i(slots), .slot_on_i(slot_on), .chr_vld_i(vld),
      .chr_i(chr), .ninth_i(ninth), .host_en_i(hen), .host_dis_i(hdis),
      .acc_o(acc), .acc_chr_o(acc_chr), .match_o(match), .rx_en_o(rx_en)
   );

   task automatic chk(string req, string what, logic [8:0] act, logic [8:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s %s act=%h exp=%h", req, what, act, exp);
      end
   endtask

   // monitor: pops the scoreboard whenever the design accepts
   always @(negedge clk) begin
      if (rst_n && acc) begin
         if (expq.size() == 0) begin
            total++; bad++;
            $display("FAIL R6 unexpected accept act=%h exp=none", acc_chr);
         end else begin
            chk(reqq.pop_front(), "accepted char", acc_chr, expq.pop_front());
         end
      end
   end

   task automatic send(string req, logic n9, logic [7:0] d);
      logic hit, take;
      @(negedge clk);
      vld = 1'b1; ninth = n9; chr = d;
      hit = (slot_on[0] && d == slots[7:0]) || (slot_on[1] && d == slots[15:8]);
      if (mode == 2'b00) take = m_en;
      else if (n9)       take = hit && keep;
      else               take = m_en;
      if (take) begin expq.push_back({n9, d}); reqq.push_back(req); end
      if (n9) m_match = hit;
      if (n9 && mode != 2'b00) begin
         if (hit && (mode == 2'b01 || mode == 2'b10)) m_en = 1'b1;
         else if (!hit && (mode == 2'b01 || mode == 2'b11)) m_en = 1'b0;
      end
      @(negedge clk);
      vld = 1'b0;
      chk(req, "rx_en", {8'd0, rx_en}, {8'd0, m_en});
      chk(req, "match", {8'd0, match}, {8'd0, m_match});
   endtask

   task automatic cmd(string req, logic e, logic d);
      @(negedge clk);
      hen = e; hdis = d;
      if (mode != 2'b01 && (e || d)) m_en = !d;
      @(negedge clk);
      hen = 1'b0; hdis = 1'b0;
      chk(req, "rx_en after cmd", {8'd0, rx_en}, {8'd0, m_en});
   endtask

   initial begin
      #(8 * 20000);
      total++; bad++;
      $display("FAIL watchdog expired act=running exp=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      chk("R10", "acc reset", {8'd0, acc}, 9'd0);
      chk("R10", "rx_en reset", {8'd0, rx_en}, 9'd0);
      chk("R10", "match reset", {8'd0, match}, 9'd0);
      rst_n = 1'b1;

      // host mode
      mode = 2'b00;
      send("R7", 1'b0, 8'h11);
      send("R1", 1'b1, 8'h5A);
      send("R3", 1'b0, 8'h12);
      cmd ("R3", 1'b1, 1'b0);
      send("R2", 1'b0, 8'h22);
      send("R3", 1'b1, 8'h77);
      send("R1", 1'b0, 8'h23);
      cmd ("R3", 1'b1, 1'b1);
      send("R7", 1'b0, 8'h24);

      // full automatic mode
      mode = 2'b01; keep = 1'b0;
      cmd ("R4", 1'b1, 1'b0);
      send("R7", 1'b0, 8'h33);
      send("R6", 1'b1, 8'h5A);
      send("R4", 1'b0, 8'h44);
      cmd ("R4", 1'b0, 1'b1);
      send("R4", 1'b1, 8'h99);
      send("R7", 1'b0, 8'h55);
      keep = 1'b1;
      send("R5", 1'b1, 8'h3C);
      send("R5", 1'b0, 8'h66);
      send("R6", 1'b1, 8'hA5);
      slot_on = 2'b01;
      send("R5", 1'b1, 8'h3C);
      slot_on = 2'b11;

      // wake mode
      mode = 2'b10; keep = 1'b0;
      send("R8", 1'b1, 8'h5A);
      send("R8", 1'b1, 8'h12);
      send("R8", 1'b0, 8'h77);
      cmd ("R8", 1'b0, 1'b1);
      send("R7", 1'b0, 8'h78);

      // sleep mode
      mode = 2'b11;
      send("R9", 1'b1, 8'h5A);
      cmd ("R9", 1'b1, 1'b0);
      send("R9", 1'b0, 8'h88);
      send("R9", 1'b1, 8'h5A);
      send("R9", 1'b1, 8'h13);
      send("R7", 1'b0, 8'h89);

      repeat (3) @(negedge clk);
      chk("R2", "scoreboard drained", expq.size(), 9'd0);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule